// File: doc/BRIEF.md
# Single-Step Trap Sequencer

This block decides when a single-step debug trap is raised. It owns the processor flags register as far as stepping is concerned, and two bits of it matter: a trap-enable bit that turns on stepping, and a resume bit that lets exactly one instruction complete without a trap on return from the debug handler. The instruction pipeline tells the block three things. When an instruction retires, a strobe is asserted. When a flags-restoring instruction (a flag pop or an interrupt return) writes a new flags value, a write strobe and its data are asserted. When the core enters an exception, an entry strobe is asserted.

The block answers with a one-cycle trap request, issued in the same cycle as the retire strobe it belongs to. It also drives a sticky step-cause bit in a debug status word. A newly written trap-enable bit takes effect only from the retire that follows the writing instruction, so the instruction after the flags write is the first one to be stepped. Clearing the bit stops trapping at once. Exception entry strips both step bits from the live flags, so the handler is never stepped itself.

Top module: `single_step_seq`

## Requirements
- R1: After synchronous reset, flags_o is all zero, dstat_o is all zero and trap_o is low.
- R2: A flags write without exception entry loads flags_wr_data_i into flags_o, visible one cycle later.
- R3: When a write sets the trap-enable bit (bit 8) while it was clear, a retire in the same cycle as the write raises no trap. The first retire in any later cycle raises trap_o, provided the resume bit is clear.
- R4: While bit 8 of flags_o is set and bit 16 is clear, every retire strobe gives trap_o high in that same cycle. trap_o is never high without a retire strobe.
- R5: A write that clears bit 8 does not affect a retire in the same cycle: that retire still traps if bit 8 was set before. No retire in a later cycle traps.
- R6: With bit 16 (resume) set, the next retire raises no trap and clears bit 16, visible one cycle later. With bit 8 still set, the retire after that traps. A flags write in the same cycle as a retire takes precedence over the clear.
- R7: Bit 16 keeps its value across cycles with no retire and no exception entry.
- R8: Exception entry clears bits 8 and 16 of flags_o one cycle later and leaves every other bit as it was. If a write arrives in the same cycle, its data is loaded with those two bits cleared.
- R9: A trap sets bit 14 of dstat_o one cycle later. The bit stays set until it is cleared, and all other dstat_o bits read zero.
- R10: dstat_clr_i clears bit 14 one cycle later. A trap in the same cycle wins and leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction completed this cycle |
| flags_wr_i | input | 1 | Flags register write from flag pop or interrupt return |
| flags_wr_data_i | input | FLAG_W | New flags value |
| exc_entry_i | input | 1 | Exception entry strobe |
| dstat_clr_i | input | 1 | Clears the step-cause bit of the debug status word |
| trap_o | output | 1 | Single-step trap request, same cycle as retire |
| flags_o | output | FLAG_W | Live flags register |
| dstat_o | output | STAT_W | Debug status word, bit 14 = single-step cause |

## Verification
The trap request is combinational from registered flag state and the retire strobe, so it is due in the cycle of the strobe itself. The bench samples it one time step after driving inputs on the falling edge, before the rising edge that would change the state. Flags and status changes pass through one register, so they are checked one time step after the next rising edge, once the inputs have been returned to idle. Same-cycle collisions are driven in a single cycle each, and their effect on the following retire is checked in a separate cycle. These collisions are a write with a retire, an exception with a write, and a trap with a status clear.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    localparam int FLAG_W = 32;
    localparam int TF_POS = 8;
    localparam int RF_POS = 16;
    localparam int STAT_W = 16;
    localparam int BS_POS = 14;

    typedef struct packed {
        logic retire;
        logic wr;
        logic exc;
    } evt_t;

    typedef struct packed {
        logic tf;
        logic rf;
    } step_bits_t;
endpackage

// File: rtl/ssq_flag_reg.sv
module ssq_flag_reg #(
    parameter int FLAG_W = ssq_pkg::FLAG_W,
    parameter int TF_POS = ssq_pkg::TF_POS,
    parameter int RF_POS = ssq_pkg::RF_POS
) (
    input  logic              clk,
    input  logic              rst,
    input  ssq_pkg::evt_t     evt,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] flags_q,
    output ssq_pkg::step_bits_t bits
);
    logic [FLAG_W-1:0] flags_nxt;

    always_comb begin
        flags_nxt = flags_q;
        if (evt.wr) begin
            flags_nxt = wr_data;
        end else if (evt.retire) begin
            flags_nxt[RF_POS] = 1'b0;
        end
        if (evt.exc) begin
            flags_nxt[TF_POS] = 1'b0;
            flags_nxt[RF_POS] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_nxt;
    end

    assign bits.tf = flags_q[TF_POS];
    assign bits.rf = flags_q[RF_POS];
endmodule

// File: rtl/ssq_step_gate.sv
module ssq_step_gate (
    input  logic                retire,
    input  ssq_pkg::step_bits_t bits,
    output logic                trap
);
    always_comb begin
        trap = retire & bits.tf & ~bits.rf;
    end
endmodule

// File: rtl/ssq_status.sv
module ssq_status #(
    parameter int STAT_W = ssq_pkg::STAT_W,
    parameter int BS_POS = ssq_pkg::BS_POS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic              clr,
    output logic [STAT_W-1:0] stat
);
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (i == BS_POS) begin : g_cause
            logic cause_q;
            always_ff @(posedge clk) begin
                if (rst)      cause_q <= 1'b0;
                else if (set) cause_q <= 1'b1;
                else if (clr) cause_q <= 1'b0;
            end
            assign stat[i] = cause_q;
        end else begin : g_zero
            assign stat[i] = 1'b0;
        end
    end
endmodule

// File: rtl/single_step_seq.sv
module single_step_seq #(
    parameter int FLAG_W = ssq_pkg::FLAG_W,
    parameter int TF_POS = ssq_pkg::TF_POS,
    parameter int RF_POS = ssq_pkg::RF_POS,
    parameter int STAT_W = ssq_pkg::STAT_W,
    parameter int BS_POS = ssq_pkg::BS_POS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              retire_i,
    input  logic              flags_wr_i,
    input  logic [FLAG_W-1:0] flags_wr_data_i,
    input  logic              exc_entry_i,
    input  logic              dstat_clr_i,
    output logic              trap_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [STAT_W-1:0] dstat_o
);
    ssq_pkg::evt_t       evt;
    ssq_pkg::step_bits_t bits;
    logic                trap;

    assign evt.retire = retire_i;
    assign evt.wr     = flags_wr_i;
    assign evt.exc    = exc_entry_i;

    ssq_flag_reg #(.FLAG_W(FLAG_W), .TF_POS(TF_POS), .RF_POS(RF_POS)) u_flags (
        .clk(clk), .rst(rst), .evt(evt), .wr_data(flags_wr_data_i),
        .flags_q(flags_o), .bits(bits)
    );

    ssq_step_gate u_gate (.retire(retire_i), .bits(bits), .trap(trap));

    ssq_status #(.STAT_W(STAT_W), .BS_POS(BS_POS)) u_stat (
        .clk(clk), .rst(rst), .set(trap), .clr(dstat_clr_i), .stat(dstat_o)
    );

    assign trap_o = trap;
endmodule

// File: rtl/ssq_checker.sv
module ssq_checker #(
    parameter int FLAG_W = ssq_pkg::FLAG_W,
    parameter int TF_POS = ssq_pkg::TF_POS,
    parameter int RF_POS = ssq_pkg::RF_POS,
    parameter int STAT_W = ssq_pkg::STAT_W,
    parameter int BS_POS = ssq_pkg::BS_POS
) (
    input logic              clk,
    input logic              rst,
    input logic              retire_i,
    input logic              flags_wr_i,
    input logic [FLAG_W-1:0] flags_wr_data_i,
    input logic              exc_entry_i,
    input logic              dstat_clr_i,
    input logic              trap_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic [STAT_W-1:0] dstat_o
);
    localparam logic [STAT_W-1:0] CAUSE_MASK = STAT_W'(1) << BS_POS;

    p_trap_needs_retire_r4: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> retire_i);

    p_wr_loads_r2: assert property (@(posedge clk) disable iff (rst)
        (flags_wr_i && !exc_entry_i) |=> (flags_o == $past(flags_wr_data_i)));

    p_rf_consumed_r6: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !flags_wr_i && !exc_entry_i && flags_o[RF_POS]) |=> !flags_o[RF_POS]);

    p_exc_strips_r8: assert property (@(posedge clk) disable iff (rst)
        exc_entry_i |=> (!flags_o[TF_POS] && !flags_o[RF_POS]));

    p_trap_marks_r9: assert property (@(posedge clk) disable iff (rst)
        trap_o |=> dstat_o[BS_POS]);

    p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (dstat_o & ~CAUSE_MASK) == '0);

    p_clr_r10: assert property (@(posedge clk) disable iff (rst)
        (dstat_clr_i && !trap_o) |=> !dstat_o[BS_POS]);
endmodule

bind single_step_seq ssq_checker #(
    .FLAG_W(FLAG_W), .TF_POS(TF_POS), .RF_POS(RF_POS), .STAT_W(STAT_W), .BS_POS(BS_POS)
) u_ssq_checker (
    .clk(clk), .rst(rst), .retire_i(retire_i), .flags_wr_i(flags_wr_i),
    .flags_wr_data_i(flags_wr_data_i), .exc_entry_i(exc_entry_i),
    .dstat_clr_i(dstat_clr_i), .trap_o(trap_o), .flags_o(flags_o), .dstat_o(dstat_o)
);

// File: tb/single_step_seq_bench.sv
module single_step_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        retire_i = 1'b0;
    logic        flags_wr_i = 1'b0;
    logic [31:0] flags_wr_data_i = '0;
    logic        exc_entry_i = 1'b0;
    logic        dstat_clr_i = 1'b0;
    logic        trap_o;
    logic [31:0] flags_o;
    logic [15:0] dstat_o;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    single_step_seq u_single_step_seq (
        .clk(clk), .rst(rst), .retire_i(retire_i), .flags_wr_i(flags_wr_i),
        .flags_wr_data_i(flags_wr_data_i), .exc_entry_i(exc_entry_i),
        .dstat_clr_i(dstat_clr_i), .trap_o(trap_o), .flags_o(flags_o), .dstat_o(dstat_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check trap in that cycle, then idle inputs after the rising edge.
    task automatic step(input logic r, input logic w, input logic [31:0] d,
                        input logic e, input logic c, input logic exp_trap, input string req);
        @(negedge clk);
        retire_i = r; flags_wr_i = w; flags_wr_data_i = d; exc_entry_i = e; dstat_clr_i = c;
        #1;
        check(req, {31'd0, trap_o}, {31'd0, exp_trap});
        @(posedge clk);
        #1;
        retire_i = 0; flags_wr_i = 0; flags_wr_data_i = '0; exc_entry_i = 0; dstat_clr_i = 0;
    endtask

    task automatic t_reset();
        check("R1 flags", flags_o, 32'h0);
        check("R1 dstat", {16'd0, dstat_o}, 32'h0);
        check("R1 trap", {31'd0, trap_o}, 32'h0);
    endtask

    task automatic t_write();
        step(0, 1, 32'h0000_0A55, 0, 0, 0, "R2 write cycle");
        check("R2 flags loaded", flags_o, 32'h0000_0A55);
        step(1, 0, '0, 0, 0, 0, "R4 no trap with bit8 clear");
    endtask

    task automatic t_tf_delay();
        step(1, 1, 32'h0000_0100, 0, 0, 0, "R3 no trap on writing retire");
        check("R3 flags", flags_o, 32'h0000_0100);
        step(1, 0, '0, 0, 0, 1, "R3 first trap next retire");
        check("R9 cause set", {16'd0, dstat_o}, 32'h0000_4000);
        step(0, 0, '0, 0, 0, 0, "R4 no trap without retire");
        step(1, 0, '0, 0, 0, 1, "R4 trap every retire");
    endtask

    task automatic t_status();
        check("R9 cause sticky", {16'd0, dstat_o}, 32'h0000_4000);
        step(0, 0, '0, 0, 1, 0, "R10 clear cycle");
        check("R10 cleared", {16'd0, dstat_o}, 32'h0);
        step(1, 0, '0, 0, 1, 1, "R10 trap with clear");
        check("R10 set wins", {16'd0, dstat_o}, 32'h0000_4000);
    endtask

    task automatic t_tf_off();
        step(1, 1, 32'h0, 0, 0, 1, "R5 old bit8 still traps");
        step(1, 0, '0, 0, 0, 0, "R5 stopped at once");
    endtask

    task automatic t_resume();
        step(0, 1, 32'h0001_0100, 0, 0, 0, "R6 write tf+rf");
        step(0, 0, '0, 0, 0, 0, "R7 idle");
        check("R7 rf held", flags_o, 32'h0001_0100);
        step(1, 0, '0, 0, 0, 0, "R6 retire suppressed");
        check("R6 rf consumed", flags_o, 32'h0000_0100);
        step(1, 0, '0, 0, 0, 1, "R6 next retire traps");
        step(1, 1, 32'h0001_0100, 0, 0, 1, "R6 write with retire");
        check("R6 write wins over clear", flags_o, 32'h0001_0100);
        step(1, 0, '0, 0, 0, 0, "R6 suppressed after iret");
    endtask

    task automatic t_exc();
        step(0, 1, 32'h0001_13FF, 0, 0, 0, "R8 preload");
        step(0, 0, '0, 1, 0, 0, "R8 entry");
        check("R8 bits stripped", flags_o, 32'h0000_12FF);
        step(1, 0, '0, 0, 0, 0, "R8 handler not stepped");
        step(0, 1, 32'h0001_0155, 1, 0, 0, "R8 entry with write");
        check("R8 write stripped", flags_o, 32'h0000_0055);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_write();
        t_tf_delay();
        t_status();
        t_tf_off();
        t_resume();
        t_exc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule